// File: doc/BRIEF.md
# Probabilistic bit unit

The unit is a tunable biased coin. On every clock where `enable` is high it takes a signed fixed-point drive value, looks up a sigmoid probability for that value, draws a uniform pseudo-random byte from its own seeded shift-register generator, and emits a 1 when the probability is strictly larger than the random byte. A drive of zero gives a fair coin. Strongly negative drives make the output almost always 0, and strongly positive drives make it almost always 1. The randomness is greatest at zero drive.

The unit is meant to sit inside a network that computes each drive value from the outputs of other units. It has no weighting, no scaling and no analog noise source. The drive is in Q4.4 format, with four integer bits including the sign and four fraction bits, so its range is -8 to +7.9375. The output is a single registered bit. A one-cycle valid strobe marks each fresh sample. There is no back-pressure: the strobe cannot be stalled, and a consumer that wants a sample must take it in the cycle the strobe is high. A consumer that needs pacing lowers `enable`. A cycle with `enable` low consumes nothing and changes nothing.

Top module: `pbit_unit`

## Requirements
- R1: Reset is synchronous and active low. A clock edge with `rst_n` low forces `bit_out` to 0 and `sample_valid` to 0, and reloads the generator with the SEED parameter. A SEED of zero is replaced by 1.
- R2: Each clock edge with `enable` high produces exactly one sample, and `sample_valid` is high in the cycle that follows. After an edge with `enable` low, `sample_valid` is low.
- R3: While `enable` is low, `bit_out` and the generator state do not change. When `enable` returns high, the random sequence continues from where it stopped.
- R4: The probability byte for drive code c is round(256 / (1 + e^(-c/16))), capped at 255, where c is the signed 8-bit code. Code 0 gives 128, which is exactly a 50% chance of a 1. Codes of ±48 (±3.0) give 244 and 12.
- R5: Code -16 (0xF0, drive -1.0) gives probability byte 69, about 27% ones. Code +16 (0x10, drive +1.0) gives 187, about 73% ones.
- R6: The comparison is strict: the output is 1 only when the probability byte is greater than the random byte. Code -128 (0x80) maps to byte 0 and never yields 1. Code 127 (0x7F) maps to 255 and yields 1 unless the random byte is 255.
- R7: The generator is a 16-bit Fibonacci LFSR that shifts toward the MSB. Its new LSB is s[15] ^ s[13] ^ s[12] ^ s[10]. Each sample uses as its random byte s[15:8] of the state held before the edge, and the state advances once per sample.
- R8: A sample uses the drive code present at the same enabled clock edge. `bit_out` shows that sample one register later, with no extra pipeline delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Take one sample at this edge |
| in_code | input | 8 | Signed Q4.4 drive value |
| bit_out | output | 1 | Registered stochastic output bit |
| sample_valid | output | 1 | High for one cycle after each sample |

## Verification
The bench builds the unit with the default 8-bit Q4.4 drive, an 8-bit probability and a 16-bit generator. It overrides the seed with a non-default value, which shows that the parameter sets the reset state. The default widths span the whole sigmoid, including both saturated ends, where a 0 or 255 entry exposes an off-by-one in the strict comparison. Because the generator polynomial and byte selection are fixed by the requirements, the bench can predict every output bit exactly. The same predictions show that pauses and mid-run resets restart the sequence at the right point.

// File: rtl/pbit_pkg.sv
`timescale 1ns/1ps
package pbit_pkg;

  // Feedback mask of a maximal-length Fibonacci LFSR for a given width.
  function automatic logic [63:0] lfsr_taps(input int width);
    case (width)
      8:       return 64'h0000_0000_0000_00B8;
      16:      return 64'h0000_0000_0000_B400;
      24:      return 64'h0000_0000_00E1_0000;
      32:      return 64'h0000_0000_8020_0003;
      default: return 64'h0000_0000_0000_B400;
    endcase
  endfunction

  // Sigmoid probability of a signed fixed-point code, scaled to prob_w bits,
  // rounded to nearest and capped at the all-ones value. Integer-only so it
  // can be evaluated while the table is elaborated.
  function automatic int sigmoid_entry(input int code, input int frac_w, input int prob_w);
    longint step_q, e_q, p_q, a, sat;
    int     mag;
    mag = (code < 0) ? -code : code;
    a   = longint'(65536) >>> frac_w;
    // exp(-2^-frac_w) in Q16 through a short series
    step_q = 65536 - a + (a * a) / 131072 - (a * a * a) / (longint'(6) * 65536 * 65536);
    e_q = 65536;
    for (int i = 0; i < mag; i++) begin
      e_q = (e_q * step_q + 32768) >>> 16;
    end
    p_q = (longint'(1) <<< 32) / (65536 + e_q);
    if (code < 0) p_q = 65536 - p_q;
    p_q = (p_q + (longint'(1) <<< (15 - prob_w))) >>> (16 - prob_w);
    sat = (longint'(1) <<< prob_w) - 1;
    if (p_q > sat) p_q = sat;
    return int'(p_q);
  endfunction

endpackage

// File: rtl/pbit_lfsr.sv
`timescale 1ns/1ps
module pbit_lfsr #(
  parameter int          WIDTH  = 16,
  parameter int          OUT_W  = 8,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [OUT_W-1:0] rand_val
);
  localparam logic [WIDTH-1:0] TAPS      = WIDTH'(pbit_pkg::lfsr_taps(WIDTH));
  localparam logic [WIDTH-1:0] SAFE_SEED = (SEED == '0) ? WIDTH'(1) : SEED;

  logic [WIDTH-1:0] state_q;
  logic             feedback;

  assign feedback = ^(state_q & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SAFE_SEED;
    end else if (advance) begin
      state_q <= {state_q[WIDTH-2:0], feedback};
    end
  end

  assign rand_val = state_q[WIDTH-1 -: OUT_W];
endmodule

// File: rtl/pbit_sigmoid_rom.sv
`timescale 1ns/1ps
module pbit_sigmoid_rom #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4,
  parameter int PROB_W = 8
) (
  input  logic [DATA_W-1:0] code,
  output logic [PROB_W-1:0] prob
);
  localparam int DEPTH = 1 << DATA_W;

  logic [PROB_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int CODE = (g >= DEPTH / 2) ? g - DEPTH : g;
    assign rom[g] = PROB_W'(pbit_pkg::sigmoid_entry(CODE, FRAC_W, PROB_W));
  end

  assign prob = rom[code];
endmodule

// File: rtl/pbit_sampler.sv
`timescale 1ns/1ps
module pbit_sampler #(
  parameter int PROB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [PROB_W-1:0] prob,
  input  logic [PROB_W-1:0] rand_val,
  output logic              bit_out,
  output logic              sample_valid
);
  logic hit;

  // strict comparison: a zero probability can never produce a one
  assign hit = (prob > rand_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_out      <= 1'b0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= enable;
      if (enable) bit_out <= hit;
    end
  end
endmodule

// File: rtl/pbit_unit.sv
`timescale 1ns/1ps
module pbit_unit #(
  parameter int               DATA_W = 8,
  parameter int               FRAC_W = 4,
  parameter int               PROB_W = 8,
  parameter int               LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DATA_W-1:0] in_code,
  output logic              bit_out,
  output logic              sample_valid
);
  logic [PROB_W-1:0] prob;
  logic [PROB_W-1:0] rand_val;

  pbit_sigmoid_rom #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .PROB_W(PROB_W)
  ) u_rom (
    .code(in_code),
    .prob(prob)
  );

  pbit_lfsr #(
    .WIDTH(LFSR_W), .OUT_W(PROB_W), .SEED(SEED)
  ) u_gen (
    .clk(clk),
    .rst_n(rst_n),
    .advance(enable),
    .rand_val(rand_val)
  );

  pbit_sampler #(
    .PROB_W(PROB_W)
  ) u_smp (
    .clk(clk),
    .rst_n(rst_n),
    .enable(enable),
    .prob(prob),
    .rand_val(rand_val),
    .bit_out(bit_out),
    .sample_valid(sample_valid)
  );
endmodule

// File: rtl/pbit_unit_chk.sv
`timescale 1ns/1ps
module pbit_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [DATA_W-1:0] in_code,
  input logic              bit_out,
  input logic              sample_valid
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic rst_seen_q = 1'b0;

  always_ff @(posedge clk) begin
    // R1
    if (rst_seen_q) begin
      reset_clears_chk: assert (!bit_out && !sample_valid);
    end
    rst_seen_q <= !rst_n;
  end

  // R2
  valid_follows_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> sample_valid);

  // R2
  no_valid_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sample_valid);

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(bit_out));

  // R6
  floor_never_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && in_code == MOST_NEG) |=> !bit_out);
endmodule

bind pbit_unit pbit_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .enable(enable),
  .in_code(in_code),
  .bit_out(bit_out),
  .sample_valid(sample_valid)
);

// File: tb/pbit_unit_test.sv
`timescale 1ns/1ps
module pbit_unit_test;
  localparam logic [15:0] TB_SEED = 16'h5A3C;
  localparam int          N_SAMP  = 2048;
  localparam int          N_VEC   = 7;
  localparam int          VEC_CODE [N_VEC] = '{-128, -48, -16, 0, 16, 48, 127};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] in_code = 8'h00;
  logic       bit_out;
  logic       sample_valid;

  int checks = 0;
  int errs   = 0;
  logic [15:0] model = TB_SEED;

  always #10 clk = ~clk;

  pbit_unit #(.SEED(TB_SEED)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .in_code(in_code),
    .bit_out(bit_out), .sample_valid(sample_valid)
  );

  function automatic int prob_of(input int code);
    real s;
    int  v;
    s = 1.0 / (1.0 + $exp(-real'(code) / 16.0));
    v = $rtoi(256.0 * s + 0.5);
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic logic [15:0] next_state(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic string tag_of(input int code);
    if (code == -128 || code == 127) return "R6";
    if (code == -16 || code == 16)  return "R5";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one enabled sample; report the observed and predicted bit
  task automatic sample(input int code, output logic got, output logic want, output logic vld);
    enable  = 1'b1;
    in_code = 8'(code);
    @(negedge clk);
    got  = bit_out;
    vld  = sample_valid;
    want = (prob_of(code) > int'(model[15:8]));
    model = next_state(model);
  endtask

  initial begin
    logic got, want, vld;
    int   mism, ones, expect_ones, held;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check(bit_out == 1'b0, "R1", "bit_out in reset", bit_out, 0);
    check(sample_valid == 1'b0, "R1", "valid in reset", sample_valid, 0);
    rst_n = 1'b1;

    // vector table walk: exact sequence (R7) and rate
    for (int v = 0; v < N_VEC; v++) begin
      mism = 0;
      ones = 0;
      for (int n = 0; n < N_SAMP; n++) begin
        sample(VEC_CODE[v], got, want, vld);
        if (got !== want || vld !== 1'b1) mism++;
        if (got) ones++;
      end
      check(mism == 0, "R7", $sformatf("bit sequence code %0d", VEC_CODE[v]), mism, 0);
      expect_ones = N_SAMP * prob_of(VEC_CODE[v]) / 256;
      check((ones - expect_ones) <= N_SAMP / 16 && (expect_ones - ones) <= N_SAMP / 16,
            tag_of(VEC_CODE[v]), $sformatf("ones at code %0d", VEC_CODE[v]), ones, expect_ones);
      if (VEC_CODE[v] == -128)
        check(ones == 0, "R6", "ones at floor code", ones, 0);
    end

    // R2 / R3: pause keeps output and generator
    do sample(127, got, want, vld); while (got != 1'b1);
    held = 0;
    for (int k = 0; k < 5; k++) begin
      enable  = 1'b0;
      in_code = 8'h80;
      @(negedge clk);
      if (sample_valid !== 1'b0) held++;
      if (bit_out !== 1'b1) held++;
    end
    check(held == 0, "R3", "hold while enable low", held, 0);
    check(sample_valid == 1'b0, "R2", "valid after idle edge", sample_valid, 0);
    mism = 0;
    for (int n = 0; n < 64; n++) begin
      sample(16, got, want, vld);
      if (got !== want || vld !== 1'b1) mism++;
    end
    check(mism == 0, "R3", "sequence resumes after pause", mism, 0);

    // R8: drive changes every cycle, each bit follows its own edge
    mism = 0;
    for (int n = 0; n < 256; n++) begin
      sample((n % 2 == 0) ? -128 : 127, got, want, vld);
      if (got !== want) mism++;
    end
    check(mism == 0, "R8", "alternating drive tracking", mism, 0);

    // R1: mid-run reset reloads seed
    do sample(127, got, want, vld); while (got != 1'b1);
    rst_n  = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    check(bit_out == 1'b0, "R1", "bit_out after mid-run reset", bit_out, 0);
    check(sample_valid == 1'b0, "R1", "valid after mid-run reset", sample_valid, 0);
    rst_n = 1'b1;
    model = TB_SEED;
    mism = 0;
    for (int n = 0; n < 128; n++) begin
      sample(0, got, want, vld);
      if (got !== want || vld !== 1'b1) mism++;
    end
    check(mism == 0, "R1", "sequence restarts from seed", mism, 0);
    check(sample_valid == 1'b1, "R2", "valid after enabled edge", sample_valid, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule